// File: doc/BRIEF.md
# Shift and Rotate Unit with Extend

This block is the shift and rotate datapath of a 32-bit execution unit. It is purely combinational. An operation class and a direction bit choose the operation: arithmetic shift, logical shift, plain rotate, rotate through the extend bit, or halfword exchange. An operand size of byte, word or long picks how many low bits of the source take part. For byte and word sizes, the bits above the selected size pass through to the result unchanged, so the result can be written straight back to the destination register.

The shift count comes from one of two places. One is a three-bit immediate field, where zero stands for eight. The other is the low six bits of a data register, which gives the count modulo 64. A memory-form input models the single-step, word-size shift of a memory operand. The block also produces the extend flag X and the condition flags N, Z, V and C. Each of these follows a per-operation rule, and the rules include a count of zero.

Top module: `shrot_x_unit`

## Requirements
- R1: Size code 0 selects 8 bits and size code 1 selects 16 bits. Size codes 2 and 3 select 32 bits. Result bits above the selected size equal the corresponding operand bits.
- R2: When `cnt_src_reg`=1, the count is `reg_cnt`, which is the register count modulo 64. When `cnt_src_reg`=0, the count is `imm_cnt`, except that `imm_cnt`=0 means a count of 8.
- R3: Operation class 0 is arithmetic and class 1 is logical. With `shift_left`=1, either class moves bits toward the MSB and fills zeros at bit 0. The last bit shifted out goes to both X and C.
- R4: Right shifts (`shift_left`=0) fill zeros at the MSB for class 1 and copies of the sign bit for class 0. The last bit out goes to X and C.
- R5: Class 2 rotates within the selected size. C takes the last bit rotated out, and X keeps `x_in`.
- R6: Class 3 rotates through X, which acts as one extra bit between the MSB and the LSB. After the rotate, C equals the final X.
- R7: With a count of zero, the result bits are unchanged. For classes 0, 1 and 2, C is 0 and X keeps `x_in`. For class 3, C equals `x_in`.
- R8: V is 1 only for a left arithmetic shift in which the MSB differs from its original value after any step. For every other case V is 0.
- R9: N is the MSB of the result at the selected size. Z is 1 when the result bits at the selected size are all zero.
- R10: Class 4 and above exchange the two 16-bit halves of the full 32-bit operand. N and Z are taken at 32 bits, C and V are 0, and X keeps `x_in`.
- R11: With `mem_form`=1, the size is word and the count is 1, whatever the size and count inputs say.
- R12: A count at or above the selected size is fully applied. A logical shift then yields zero, and an arithmetic right shift yields all copies of the sign bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_kind | input | 3 | Operation class: 0 arith, 1 logical, 2 rotate, 3 rotate via X, 4+ swap |
| shift_left | input | 1 | 1 = toward MSB, 0 = toward LSB |
| size_sel | input | 2 | 0 byte, 1 word, 2/3 long |
| cnt_src_reg | input | 1 | 1 = count from register, 0 = immediate |
| imm_cnt | input | 3 | Immediate count, 0 encodes 8 |
| reg_cnt | input | 6 | Low six bits of the count register |
| mem_form | input | 1 | Memory form: word size, count 1 |
| operand | input | 32 | Source and destination register value |
| x_in | input | 1 | Incoming extend flag |
| result | output | 32 | Shifted value merged over the operand |
| x_out | output | 1 | Extend flag |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| v_out | output | 1 | Overflow flag |
| c_out | output | 1 | Carry flag |

## Verification
There are no registers between the inputs and the outputs. The result and all five flags are due in the same cycle that a new operand, count and operation class are applied. The bench applies each stimulus just after a falling clock edge and samples one time unit later. That point is well before the next rising edge, so no check depends on the order of events at an edge. The expected values are worked out by hand from the bit rules for each operation. This includes the multi-step cases, where the last bit out, the extend bit or the overflow decides the flags.

// File: rtl/shrot_pkg.sv
// Shared types and helpers for the shift/rotate unit.
// Assumes a 32-bit datapath with byte and word sub-sizes.
package shrot_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;
    localparam int BYTE_W = 8;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [2:0] {
        OPK_ARITH = 3'd0,
        OPK_LOGIC = 3'd1,
        OPK_ROT   = 3'd2,
        OPK_ROTX  = 3'd3,
        OPK_SWAP  = 3'd4
    } opk_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } size_e;

    // Number of active bits for a size code (codes 2 and 3 mean long).
    function automatic int size_bits(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_bits = BYTE_W;
            SZ_WORD: size_bits = HALF_W;
            default: size_bits = DATA_W;
        endcase
    endfunction

    // Mask covering the active bits of a size code.
    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        size_mask = {DATA_W{1'b1}} >> (DATA_W - size_bits(sz));
    endfunction
endpackage

// File: rtl/shrot_decode.sv
// Resolves the effective shift count and operand size.
// Assumes the register count is already reduced to its low CNT_W bits.
module shrot_decode
    import shrot_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic [2:0]    op_kind,
    input  logic [1:0]    size_sel,
    input  logic          mem_form,
    input  logic          cnt_src_reg,
    input  logic [2:0]    imm_cnt,
    input  logic [CW-1:0] reg_cnt,
    output logic [CW-1:0] cnt,
    output logic [1:0]    eff_sz
);
    localparam logic [CW-1:0] IMM_ZERO_MEANS = CW'(8);

    // Pick the count source; memory form forces a single step.
    always_comb begin
        if (mem_form)
            cnt = CW'(1);
        else if (cnt_src_reg)
            cnt = reg_cnt;
        else if (imm_cnt == 3'd0)
            cnt = IMM_ZERO_MEANS;
        else
            cnt = CW'(imm_cnt);
    end

    // Pick the operating size; swap always works on the full register.
    always_comb begin
        if (op_kind >= OPK_SWAP)
            eff_sz = SZ_LONG;
        else if (mem_form)
            eff_sz = SZ_WORD;
        else
            eff_sz = size_sel;
    end
endmodule

// File: rtl/shrot_core.sv
// Step-by-step shift/rotate engine over the active bits of the operand.
// Assumes the count fits in CW bits; each loop step models one bit move.
module shrot_core
    import shrot_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic [2:0]    op_kind,
    input  logic          shift_left,
    input  logic [1:0]    eff_sz,
    input  logic [CW-1:0] cnt,
    input  logic [W-1:0]  operand,
    input  logic          x_in,
    output logic [W-1:0]  val_out,
    output logic          x_out,
    output logic          c_out,
    output logic          v_out
);
    localparam int STEPS = (1 << CW) - 1;
    localparam int HW    = W / 2;

    // Apply up to STEPS single-bit moves, tracking X, C and MSB changes.
    always_comb begin
        logic [W-1:0] mask;
        logic [W-1:0] val;
        logic         xb, cb, ovf, top0, outb, fill;
        int           msb;
        msb  = size_bits(eff_sz) - 1;
        mask = size_mask(eff_sz);
        val  = operand & mask;
        xb   = x_in;
        cb   = (op_kind == OPK_ROTX) ? x_in : 1'b0;
        ovf  = 1'b0;
        top0 = val[msb];
        outb = 1'b0;
        fill = 1'b0;
        if (op_kind >= OPK_SWAP) begin
            val = {operand[HW-1:0], operand[W-1:HW]};
        end else begin
            for (int i = 0; i < STEPS; i++) begin
                if (i < int'(cnt)) begin
                    if (shift_left) begin
                        outb = val[msb];
                        val  = (val << 1) & mask;
                        if (op_kind == OPK_ROT)
                            val[0] = outb;
                        else if (op_kind == OPK_ROTX)
                            val[0] = xb;
                    end else begin
                        outb = val[0];
                        case (op_kind)
                            OPK_ARITH: fill = val[msb];
                            OPK_ROT:   fill = outb;
                            OPK_ROTX:  fill = xb;
                            default:   fill = 1'b0;
                        endcase
                        val      = val >> 1;
                        val[msb] = fill;
                    end
                    cb = outb;
                    if (op_kind != OPK_ROT)
                        xb = outb;
                    if (op_kind == OPK_ARITH && shift_left && val[msb] != top0)
                        ovf = 1'b1;
                end
            end
        end
        val_out = val;
        x_out   = xb;
        c_out   = cb;
        v_out   = ovf;
    end

    // Guard the zero-count carry rule and the plain-rotate extend rule.
    always_comb begin
        if (!$isunknown({op_kind, cnt, c_out, x_out, x_in})) begin
            if (cnt == '0 && op_kind < OPK_ROTX)
                assert_zero_cnt_clears_c_R7: assert (c_out == 1'b0);
            if (op_kind == OPK_ROT)
                assert_rot_keeps_x_R5: assert (x_out == x_in);
            if (op_kind == OPK_ROTX)
                assert_rotx_c_tracks_x_R6: assert (c_out == x_out);
        end
    end
endmodule

// File: rtl/shrot_merge.sv
// Merges the shifted field over the destination and derives N and Z.
// Assumes val is already zero above the active size.
module shrot_merge
    import shrot_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [1:0]   eff_sz,
    input  logic [W-1:0] operand,
    input  logic [W-1:0] val,
    output logic [W-1:0] result,
    output logic         n_out,
    output logic         z_out
);
    // Keep the untouched upper bits and take flags at the active size.
    always_comb begin
        logic [W-1:0] mask;
        mask   = size_mask(eff_sz);
        result = (operand & ~mask) | (val & mask);
        n_out  = val[size_bits(eff_sz) - 1];
        z_out  = ((val & mask) == '0);
    end
endmodule

// File: rtl/shrot_x_unit.sv
// Top of the shift/rotate unit with extend bit: decode, step engine, merge.
// Purely combinational; results follow the inputs in the same cycle.
module shrot_x_unit
    import shrot_pkg::*;
(
    input  logic [2:0]        op_kind,
    input  logic              shift_left,
    input  logic [1:0]        size_sel,
    input  logic              cnt_src_reg,
    input  logic [2:0]        imm_cnt,
    input  logic [CNT_W-1:0]  reg_cnt,
    input  logic              mem_form,
    input  logic [DATA_W-1:0] operand,
    input  logic              x_in,
    output logic [DATA_W-1:0] result,
    output logic              x_out,
    output logic              n_out,
    output logic              z_out,
    output logic              v_out,
    output logic              c_out
);
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        eff_sz;
    logic [DATA_W-1:0] val;

    shrot_decode #(.CW(CNT_W)) u_decode (
        .op_kind     (op_kind),
        .size_sel    (size_sel),
        .mem_form    (mem_form),
        .cnt_src_reg (cnt_src_reg),
        .imm_cnt     (imm_cnt),
        .reg_cnt     (reg_cnt),
        .cnt         (cnt),
        .eff_sz      (eff_sz)
    );

    shrot_core #(.W(DATA_W), .CW(CNT_W)) u_core (
        .op_kind    (op_kind),
        .shift_left (shift_left),
        .eff_sz     (eff_sz),
        .cnt        (cnt),
        .operand    (operand),
        .x_in       (x_in),
        .val_out    (val),
        .x_out      (x_out),
        .c_out      (c_out),
        .v_out      (v_out)
    );

    shrot_merge #(.W(DATA_W)) u_merge (
        .eff_sz  (eff_sz),
        .operand (operand),
        .val     (val),
        .result  (result),
        .n_out   (n_out),
        .z_out   (z_out)
    );

    // Check port-level rules: upper bits kept, V only on ASL, swap halves.
    always_comb begin
        if (!$isunknown({op_kind, shift_left, size_sel, mem_form, operand, result, v_out, c_out})) begin
            if (!mem_form && op_kind < OPK_SWAP && size_sel == SZ_BYTE)
                assert_upper_kept_R1: assert (result[DATA_W-1:BYTE_W] == operand[DATA_W-1:BYTE_W]);
            if (!(op_kind == OPK_ARITH && shift_left))
                assert_v_only_asl_R8: assert (v_out == 1'b0);
            if (op_kind >= OPK_SWAP)
                assert_swap_halves_R10: assert (result[HALF_W-1:0] == operand[DATA_W-1:HALF_W]
                                                && c_out == 1'b0);
        end
    end
endmodule

// File: tb/tb_shrot_x_unit.sv
// Directed bench for the shift/rotate unit; one task per scenario.
module tb_shrot_x_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_kind = '0;
    logic        shift_left = 1'b0;
    logic [1:0]  size_sel = '0;
    logic        cnt_src_reg = 1'b0;
    logic [2:0]  imm_cnt = '0;
    logic [5:0]  reg_cnt = '0;
    logic        mem_form = 1'b0;
    logic [31:0] operand = '0;
    logic        x_in = 1'b0;
    logic [31:0] result;
    logic        x_out, n_out, z_out, v_out, c_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shrot_x_unit dut (
        .op_kind(op_kind), .shift_left(shift_left), .size_sel(size_sel),
        .cnt_src_reg(cnt_src_reg), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt),
        .mem_form(mem_form), .operand(operand), .x_in(x_in),
        .result(result), .x_out(x_out), .n_out(n_out), .z_out(z_out),
        .v_out(v_out), .c_out(c_out)
    );

    // Compare one value and log a failure line on mismatch.
    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Apply one operation after a falling edge, then let it settle.
    task automatic apply(input logic [2:0] k, input logic l, input logic [1:0] sz,
                         input logic src, input logic [2:0] imm, input logic [5:0] rc,
                         input logic mem, input logic [31:0] opnd, input logic x);
        @(negedge clk);
        op_kind = k; shift_left = l; size_sel = sz; cnt_src_reg = src;
        imm_cnt = imm; reg_cnt = rc; mem_form = mem; operand = opnd; x_in = x;
        #1;
    endtask

    // Check result and flags packed as {X,N,Z,V,C}.
    task automatic expect_out(input string req, input logic [31:0] r, input logic [4:0] f);
        chk(req, "result", result, r);
        chk(req, "flags XNZVC", 32'({x_out, n_out, z_out, v_out, c_out}), 32'(f));
    endtask

    task automatic t_idle;        // all-zero inputs: ASR byte by 8 of zero
        apply(3'd0, 0, 2'd0, 0, 3'd0, 6'd0, 0, 32'h0, 0);
        expect_out("R9 idle", 32'h0, 5'b00100);
    endtask

    task automatic t_left_shift;  // R3 with R1 merge
        apply(3'd1, 1, 2'd0, 0, 3'd1, 6'd0, 0, 32'hAABBCC81, 0);
        expect_out("R3 R1 lsl byte", 32'hAABBCC02, 5'b10001);
    endtask

    task automatic t_right_shift; // R4 arithmetic word, logical long from register count
        apply(3'd0, 0, 2'd1, 0, 3'd2, 6'd0, 0, 32'h12348001, 0);
        expect_out("R4 asr word", 32'h1234E000, 5'b01000);
        apply(3'd1, 0, 2'd2, 1, 3'd5, 6'd1, 0, 32'h80000003, 0);
        expect_out("R4 R2 lsr long reg", 32'h40000001, 5'b10001);
    endtask

    task automatic t_rotate;      // R5
        apply(3'd2, 1, 2'd0, 0, 3'd1, 6'd0, 0, 32'h00000081, 1);
        expect_out("R5 rol byte", 32'h00000003, 5'b10001);
        apply(3'd2, 0, 2'd1, 0, 3'd1, 6'd0, 0, 32'hFFFF0001, 0);
        expect_out("R5 ror word", 32'hFFFF8000, 5'b01001);
    endtask

    task automatic t_rotate_x;    // R6
        apply(3'd3, 1, 2'd0, 0, 3'd1, 6'd0, 0, 32'h00000080, 0);
        expect_out("R6 roxl byte 1", 32'h00000000, 5'b10101);
        apply(3'd3, 1, 2'd0, 0, 3'd2, 6'd0, 0, 32'h00000080, 0);
        expect_out("R6 roxl byte 2", 32'h00000001, 5'b00000);
        apply(3'd3, 0, 2'd3, 0, 3'd1, 6'd0, 0, 32'h00000001, 1);
        expect_out("R6 roxr long", 32'h80000000, 5'b11001);
    endtask

    task automatic t_zero_count;  // R7
        apply(3'd1, 1, 2'd2, 1, 3'd3, 6'd0, 0, 32'h80000000, 1);
        expect_out("R7 lsl zero", 32'h80000000, 5'b11000);
        apply(3'd3, 1, 2'd2, 1, 3'd3, 6'd0, 0, 32'h80000000, 1);
        expect_out("R7 roxl zero", 32'h80000000, 5'b11001);
        apply(3'd2, 0, 2'd2, 1, 3'd3, 6'd0, 0, 32'h00000005, 0);
        expect_out("R7 ror zero", 32'h00000005, 5'b00000);
    endtask

    task automatic t_overflow;    // R8 and R9 N at byte size
        apply(3'd0, 1, 2'd0, 0, 3'd1, 6'd0, 0, 32'h00000040, 0);
        expect_out("R8 asl sets v", 32'h00000080, 5'b01010);
        apply(3'd0, 1, 2'd0, 0, 3'd1, 6'd0, 0, 32'h000000C0, 0);
        expect_out("R8 asl keeps msb", 32'h00000080, 5'b11001);
        apply(3'd0, 1, 2'd0, 0, 3'd2, 6'd0, 0, 32'h00000060, 0);
        expect_out("R8 asl change mid", 32'h00000080, 5'b11011);
        apply(3'd1, 1, 2'd0, 0, 3'd1, 6'd0, 0, 32'h00000040, 0);
        expect_out("R8 R9 lsl no v", 32'h00000080, 5'b01000);
    endtask

    task automatic t_swap;        // R10
        apply(3'd4, 0, 2'd0, 0, 3'd1, 6'd0, 0, 32'h12345678, 1);
        expect_out("R10 swap", 32'h56781234, 5'b10000);
        apply(3'd4, 1, 2'd1, 0, 3'd1, 6'd0, 0, 32'h00008000, 0);
        expect_out("R10 swap n", 32'h80000000, 5'b01000);
    endtask

    task automatic t_mem_form;    // R11
        apply(3'd1, 1, 2'd0, 1, 3'd0, 6'd5, 1, 32'h12348001, 0);
        expect_out("R11 mem form", 32'h12340002, 5'b10001);
    endtask

    task automatic t_long_count;  // R12 and R2 immediate eight
        apply(3'd1, 1, 2'd0, 1, 3'd0, 6'd9, 0, 32'hFFFFFF81, 1);
        expect_out("R12 lsl past size", 32'hFFFFFF00, 5'b00100);
        apply(3'd0, 0, 2'd0, 1, 3'd0, 6'd10, 0, 32'h00000080, 0);
        expect_out("R12 asr past size", 32'h000000FF, 5'b11001);
        apply(3'd1, 0, 2'd1, 0, 3'd0, 6'd0, 0, 32'h000012B4, 0);
        expect_out("R2 imm zero is 8", 32'h00000012, 5'b10001);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_left_shift();
        t_right_shift();
        t_rotate();
        t_rotate_x();
        t_zero_count();
        t_overflow();
        t_swap();
        t_mem_form();
        t_long_count();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule